// File: doc/BRIEF.md
# Bidirectional Shift-Latch Output Driver

This block is the logic core of a wide serial-to-parallel output driver. Serial data enters a shift register from one of two bidirectional serial pins, and the `dir` input picks which one. The other pin presents the final stage so that several drivers can be chained. A bank of latches captures the register contents under `latch_en`. A blank/polarity stage then forces the parallel outputs high or low, inverts the latched data, or passes it through unchanged.

Everything runs on the serial clock `clk`. The latch is synchronous. It loads on every edge where `latch_en` is high, and it loads once more on the edge where `latch_en` is first seen low. After that it holds. The parallel output bus is registered, so it follows the latch and the mode inputs one clock later. Channel k (k = 1..NCH) appears on bit k-1 of `chan_out`.

Top module: `shift_latch_driver`

## Requirements
- R1: A synchronous active-high `rst` clears the shift register, the latches and `chan_out`. On the edge after `rst`, `chan_out` is all zeros and both serial outputs are 0.
- R2: With `dir` = 0, each rising edge of `clk` moves every stage one step toward channel 1. `pin_a_in` enters channel NCH. `pin_b_out` shows the channel 1 stage.
- R3: With `dir` = 1, each rising edge moves every stage one step toward channel NCH. `pin_b_in` enters channel 1. `pin_a_out` shows the channel NCH stage.
- R4: Only the pin in the serial-output role has its enable high. `pin_b_oe` = 1 when `dir` = 0, and `pin_a_oe` = 1 when `dir` = 1. The other enable is 0.
- R5: Shifting and the serial outputs do not depend on `latch_en`, `blank_n` or `polarity`.
- R6: On an edge where `latch_en` is 1, the latches take the shift register contents as they were before that edge.
- R7: On the first edge where `latch_en` is 0 after it was 1, the latches load once more. While `latch_en` stays 0 after that, they hold.
- R8: `blank_n` = 0 with `polarity` = 0 drives every bit of `chan_out` to 1 on the next edge.
- R9: `blank_n` = 0 with `polarity` = 1 drives every bit of `chan_out` to 0 on the next edge.
- R10: `blank_n` = 1 with `polarity` = 0 drives `chan_out` to the bitwise inverse of the latches on the next edge.
- R11: `blank_n` = 1 with `polarity` = 1 drives `chan_out` to the latch contents on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial shift clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| dir | input | 1 | Shift direction: 0 toward channel 1, 1 toward channel NCH |
| pin_a_in | input | 1 | Serial pin A input view (data in when dir=0) |
| pin_a_out | output | 1 | Serial pin A output view (channel NCH stage) |
| pin_a_oe | output | 1 | Serial pin A output enable |
| pin_b_in | input | 1 | Serial pin B input view (data in when dir=1) |
| pin_b_out | output | 1 | Serial pin B output view (channel 1 stage) |
| pin_b_oe | output | 1 | Serial pin B output enable |
| latch_en | input | 1 | Latch enable: load while high, load once more on the edge it falls |
| blank_n | input | 1 | Active-low blank: 0 forces all outputs |
| polarity | input | 1 | With blank_n=0 picks the forced level; with blank_n=1 picks pass (1) or invert (0) |
| chan_out | output | NCH | Registered parallel outputs, bit k-1 is channel k |

## Verification
The assertions assume that every input is a clean 0 or 1 at each rising edge of `clk` and that `rst` is asserted before the first edge that matters. The bench drives all inputs only on falling edges and holds `rst` high for several cycles at the start. It uses no X or Z values, so the one-edge relations between mode inputs, latch load and shift input hold in every cycle outside reset. Fully shifting random frames through in both directions, with `latch_en` held low, pulsed or kept high, covers both the chaining and the transparent cases.

// File: rtl/sld_pkg.sv
package sld_pkg;

  typedef enum logic [1:0] {
    MODE_FORCE_HI = 2'd0,
    MODE_FORCE_LO = 2'd1,
    MODE_INVERT   = 2'd2,
    MODE_PASS     = 2'd3
  } out_mode_e;

  // blank_n selects forced vs data path; polarity selects level or sense
  function automatic out_mode_e decode_mode(input logic blank_n, input logic polarity);
    return out_mode_e'({blank_n, polarity});
  endfunction

endpackage

// File: rtl/sld_shift.sv
module sld_shift #(
  parameter int NCH = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           dir,
  input  logic           din_a,
  input  logic           din_b,
  output logic [NCH-1:0] stages
);

  logic [NCH-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
    end else if (!dir) begin
      sreg <= {din_a, sreg[NCH-1:1]};
    end else begin
      sreg <= {sreg[NCH-2:0], din_b};
    end
  end

  assign stages = sreg;

  // R2
  fwd_entry_chk: assert property (@(posedge clk) disable iff (rst)
    !dir |=> sreg[NCH-1] == $past(din_a));

  // R2
  fwd_move_chk: assert property (@(posedge clk) disable iff (rst)
    !dir |=> sreg[0] == $past(sreg[1]));

  // R3
  rev_entry_chk: assert property (@(posedge clk) disable iff (rst)
    dir |=> sreg[0] == $past(din_b));

  // R3
  rev_move_chk: assert property (@(posedge clk) disable iff (rst)
    dir |=> sreg[NCH-1] == $past(sreg[NCH-2]));

endmodule

// File: rtl/sld_latch.sv
module sld_latch #(
  parameter int NCH = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           latch_en,
  input  logic [NCH-1:0] src,
  output logic [NCH-1:0] held
);

  logic           le_q;
  logic [NCH-1:0] lat;
  logic           load;

  assign load = latch_en | le_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      le_q <= 1'b0;
      lat  <= '0;
    end else begin
      le_q <= latch_en;
      if (load) lat <= src;
    end
  end

  assign held = lat;

  // R6
  load_chk: assert property (@(posedge clk) disable iff (rst)
    latch_en |=> lat == $past(src));

  // R7
  fall_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!latch_en && le_q) |=> lat == $past(src));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!latch_en && !le_q) |=> $stable(lat));

endmodule

// File: rtl/sld_outmode.sv
module sld_outmode
  import sld_pkg::*;
#(
  parameter int NCH = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           blank_n,
  input  logic           polarity,
  input  logic [NCH-1:0] held,
  output logic [NCH-1:0] dout
);

  out_mode_e      mode;
  logic [NCH-1:0] nxt;

  assign mode = decode_mode(blank_n, polarity);

  always_comb begin
    unique case (mode)
      MODE_FORCE_HI: nxt = '1;
      MODE_FORCE_LO: nxt = '0;
      MODE_INVERT:   nxt = ~held;
      default:       nxt = held;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= nxt;
  end

  // R8
  force_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (!blank_n && !polarity) |=> (&dout));

  // R9
  force_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (!blank_n && polarity) |=> (dout == '0));

  // R10
  invert_chk: assert property (@(posedge clk) disable iff (rst)
    (blank_n && !polarity) |=> (dout == ~$past(held)));

  // R11
  pass_chk: assert property (@(posedge clk) disable iff (rst)
    (blank_n && polarity) |=> (dout == $past(held)));

endmodule

// File: rtl/shift_latch_driver.sv
module shift_latch_driver #(
  parameter int NCH = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           dir,
  input  logic           pin_a_in,
  output logic           pin_a_out,
  output logic           pin_a_oe,
  input  logic           pin_b_in,
  output logic           pin_b_out,
  output logic           pin_b_oe,
  input  logic           latch_en,
  input  logic           blank_n,
  input  logic           polarity,
  output logic [NCH-1:0] chan_out
);

  localparam int LAST = NCH - 1;

  logic [NCH-1:0] stages;
  logic [NCH-1:0] held;

  sld_shift #(.NCH(NCH)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .dir    (dir),
    .din_a  (pin_a_in),
    .din_b  (pin_b_in),
    .stages (stages)
  );

  sld_latch #(.NCH(NCH)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .latch_en (latch_en),
    .src      (stages),
    .held     (held)
  );

  sld_outmode #(.NCH(NCH)) u_outmode (
    .clk      (clk),
    .rst      (rst),
    .blank_n  (blank_n),
    .polarity (polarity),
    .held     (held),
    .dout     (chan_out)
  );

  // each pin always carries its end stage; only the output-role pin is enabled
  assign pin_a_out = stages[LAST];
  assign pin_b_out = stages[0];
  assign pin_a_oe  = dir;
  assign pin_b_oe  = ~dir;

  // R4
  always_comb begin
    oe_excl_chk: assert (pin_a_oe != pin_b_oe);
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (chan_out == '0));

endmodule

// File: tb/shift_latch_driver_tb.sv
module shift_latch_driver_tb;

  localparam int NCH = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dir = 1'b0;
  logic pin_a_in = 1'b0;
  logic pin_b_in = 1'b0;
  logic latch_en = 1'b0;
  logic blank_n = 1'b1;
  logic polarity = 1'b1;
  logic pin_a_out, pin_a_oe, pin_b_out, pin_b_oe;
  logic [NCH-1:0] chan_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  shift_latch_driver #(.NCH(NCH)) u_dut (
    .clk(clk), .rst(rst), .dir(dir),
    .pin_a_in(pin_a_in), .pin_a_out(pin_a_out), .pin_a_oe(pin_a_oe),
    .pin_b_in(pin_b_in), .pin_b_out(pin_b_out), .pin_b_oe(pin_b_oe),
    .latch_en(latch_en), .blank_n(blank_n), .polarity(polarity),
    .chan_out(chan_out)
  );

  // behavioural reference: index 1..NCH = channel number
  bit m_sr[1:NCH];
  bit m_lat[1:NCH];
  bit m_out[1:NCH];
  bit m_le_prev;
  int m_mode_prev;   // 8..11 = requirement whose mode produced m_out, 1 = reset
  bit m_sr_next[1:NCH];

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 1; k <= NCH; k++) begin m_sr[k] = 0; m_lat[k] = 0; m_out[k] = 0; end
      m_le_prev = 0;
      m_mode_prev = 1;
    end else begin
      for (int k = 1; k <= NCH; k++) begin
        if (!blank_n) m_out[k] = !polarity;
        else          m_out[k] = polarity ? m_lat[k] : !m_lat[k];
      end
      m_mode_prev = !blank_n ? (polarity ? 9 : 8) : (polarity ? 11 : 10);
      if (latch_en || m_le_prev)
        for (int k = 1; k <= NCH; k++) m_lat[k] = m_sr[k];
      m_le_prev = latch_en;
      for (int k = 1; k <= NCH; k++) begin
        if (!dir) m_sr_next[k] = (k == NCH) ? pin_a_in : m_sr[k+1];
        else      m_sr_next[k] = (k == 1)   ? pin_b_in : m_sr[k-1];
      end
      for (int k = 1; k <= NCH; k++) m_sr[k] = m_sr_next[k];
    end
  end

  function automatic logic [NCH-1:0] model_vec();
    logic [NCH-1:0] v;
    for (int k = 1; k <= NCH; k++) v[k-1] = m_out[k];
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // sample at falling edge, before new inputs are applied
  task automatic compare_all();
    logic [NCH-1:0] e;
    e = model_vec();
    case (m_mode_prev)
      1:  chk(chan_out === e, "R1 chan_out", chan_out, e);
      8:  chk(chan_out === e, "R8 chan_out", chan_out, e);
      9:  chk(chan_out === e, "R9 chan_out", chan_out, e);
      10: chk(chan_out === e, "R10 R6 R7 chan_out", chan_out, e);
      default: chk(chan_out === e, "R11 R6 R7 chan_out", chan_out, e);
    endcase
    if (!dir) chk(pin_b_out === m_sr[1], "R2 R5 serial out B", pin_b_out, m_sr[1]);
    else      chk(pin_a_out === m_sr[NCH], "R3 R5 serial out A", pin_a_out, m_sr[NCH]);
    chk(pin_a_oe === dir && pin_b_oe === !dir, "R4 oe", {pin_a_oe, pin_b_oe}, {dir, !dir});
  endtask

  task automatic step(input bit d, input bit din, input bit le, input bit bn, input bit pol);
    @(negedge clk);
    compare_all();
    dir = d; latch_en = le; blank_n = bn; polarity = pol;
    if (!d) begin pin_a_in = din; pin_b_in = $urandom_range(0, 1); end
    else    begin pin_b_in = din; pin_a_in = $urandom_range(0, 1); end
  endtask

  // shift one full frame with fixed controls
  task automatic frame(input bit d, input bit le, input bit bn, input bit pol);
    for (int i = 0; i < NCH; i++) step(d, 1'($urandom_range(0, 1)), le, bn, pol);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(chan_out === '0, "R1 reset chan_out", chan_out, '0);
    chk(pin_a_out === 1'b0 && pin_b_out === 1'b0, "R1 reset serial", {pin_a_out, pin_b_out}, '0);
    rst = 1'b0;

    // R2 chained load toward channel 1, latch held, pass mode
    frame(1'b0, 1'b0, 1'b1, 1'b1);
    frame(1'b0, 1'b0, 1'b1, 1'b1);          // first frame exits on pin B
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);     // R6 latch pulse
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);     // R7 falling edge load
    repeat (6) step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    // R8..R11 all four modes on held data
    repeat (3) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    repeat (3) step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    repeat (3) step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);

    // R3 chained load toward channel NCH, transparent latch
    frame(1'b1, 1'b1, 1'b1, 1'b1);
    frame(1'b1, 1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    repeat (4) step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);

    // R5 shifting while controls toggle randomly
    for (int i = 0; i < 600; i++)
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));

    // mid-run reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(chan_out === '0, "R1 second reset", chan_out, '0);
    rst = 1'b0;
    frame(1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule